// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 17-bit buses, an A side and a B side, with one data path in each direction. Each path stores its data in a holding register and can pass data through three ways. With its latch enable high, the path follows its input. With the latch enable low, the path holds the value it last took. With the latch enable low and the path's clock enabled, a rising edge of the path's capture clock loads new data. Each pad is split into a separate input, output and output-enable, so the tri-state drivers sit outside the block.

All logic runs on one core clock. The two per-direction capture clocks are sampled as levels, and a rising edge is a low-to-high change between two core cycles. The enable for the B-side drivers is taken only on the A-to-B capture edge. A copy of the A-to-B capture clock, delayed by one core cycle, is sent out with the B data. The data it goes with is therefore already on the B outputs when that clock copy rises.

Top module: `bus_xcvr`

## Requirements
- R1: Each direction carries `W` = 17 data bits, and both directions follow the same rules R2 to R6.
- R2: While a direction's latch enable (`ab_le` / `ba_le`, active high) is 1, its output equals its input in the same cycle, with no register in the path.
- R3: When the latch enable falls, the output keeps the input value from the last core cycle in which the enable was high. It keeps that value while the enable stays low and no enabled capture edge occurs.
- R4: A capture edge loads the input into the holding register when the latch enable is low and the active-low clock enable is 0. A capture edge is a direction clock that is 0 at one core edge and 1 at the next. The loaded value shows on the output right after the core edge that saw the clock at 1.
- R5: A capture edge while the clock enable is 1 leaves the output unchanged.
- R6: When the latch enable is 1 in the same cycle as an enabled capture edge, the output still follows the input combinationally (transparent wins).
- R7: `b_oe` changes only on an A-to-B capture edge. At that edge it becomes the inverse of the active-low `ab_oe_n`, whatever `ab_ce_n` is. `a_oe` is the inverse of `ba_oe_n`, applied at once.
- R8: `fwd_clk` is `ab_clk_in` delayed by one core cycle. In the cycle where `fwd_clk` rises after an enabled A-to-B capture, `b_out` already carries the captured word.
- R9: While `rst` is high, both holding registers clear to zero and `b_oe`, `a_oe` and `fwd_clk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 17 | Data received from the A pads |
| a_out | output | 17 | Data driven onto the A pads |
| a_oe | output | 1 | A pad driver enable |
| b_in | input | 17 | Data received from the B pads |
| b_out | output | 17 | Data driven onto the B pads |
| b_oe | output | 1 | B pad driver enable |
| ab_le | input | 1 | A-to-B latch enable, active high |
| ab_clk_in | input | 1 | A-to-B capture clock level |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | B output enable request, active low, taken on capture edge |
| ba_le | input | 1 | B-to-A latch enable, active high |
| ba_clk_in | input | 1 | B-to-A capture clock level |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | A output enable, active low |
| fwd_clk | output | 1 | Forwarded copy of the A-to-B clock |

## Verification
Two pairs of functions can land in the same core cycle. The first pair is a latch enable held high and an enabled capture edge on the same path. The bench raises both together, then changes the input in the following cycle, and expects the output to follow that new input. The output must not stay on the captured word. The second pair is a capture edge that both loads data and takes a new B enable. The bench then checks that `b_out`, `b_oe` and a rising `fwd_clk` all show up in the same sampled cycle, and that `fwd_clk` was still low one cycle before.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int DATA_W = 17;

    typedef enum logic [1:0] {
        PATH_KEEP = 2'd0,
        PATH_PASS = 2'd1,
        PATH_LOAD = 2'd2
    } path_mode_e;

    typedef struct packed {
        logic le;
        logic dclk;
        logic ce_n;
    } dir_ctrl_t;

    // Transparent beats the capture edge; a capture needs its enable low.
    function automatic path_mode_e pick_mode(dir_ctrl_t c, logic edge_seen);
        if (c.le)
            return PATH_PASS;
        else if (edge_seen && !c.ce_n)
            return PATH_LOAD;
        else
            return PATH_KEEP;
    endfunction

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  dir_ctrl_t    ctrl,
    output logic [W-1:0] dout,
    output logic         edge_seen,
    output logic         dclk_q
);

    logic [W-1:0] hold_q;
    path_mode_e   mode;

    assign edge_seen = ctrl.dclk & ~dclk_q;
    assign mode      = pick_mode(ctrl, edge_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            dclk_q <= 1'b0;
        end else begin
            dclk_q <= ctrl.dclk;
            if (mode != PATH_KEEP)
                hold_q <= din;
        end
    end

    assign dout = (mode == PATH_PASS) ? din : hold_q;

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.le && !(edge_seen && !ctrl.ce_n)) |=> (hold_q == $past(hold_q))) // R3
        else $error("hold register moved without cause");

    AST_LOAD_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && !ctrl.ce_n && !ctrl.le) |=> (hold_q == $past(din))) // R4
        else $error("enabled capture edge did not load");

    AST_GATED_EDGE: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && ctrl.ce_n && !ctrl.le) |=> $stable(hold_q)) // R5
        else $error("gated capture edge changed storage");

endmodule

// File: rtl/xcvr_oe_sync.sv
module xcvr_oe_sync (
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    input  logic oe_n,
    output logic drv_en
);

    always_ff @(posedge clk) begin
        if (rst)
            drv_en <= 1'b0;
        else if (edge_seen)
            drv_en <= ~oe_n;
    end

    AST_OE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !edge_seen |=> $stable(drv_en)) // R7
        else $error("driver enable moved off the capture edge");

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_le,
    input  logic         ab_clk_in,
    input  logic         ab_ce_n,
    input  logic         ab_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk_in,
    input  logic         ba_ce_n,
    input  logic         ba_oe_n,
    output logic         fwd_clk
);

    dir_ctrl_t ab_ctrl, ba_ctrl;
    logic      ab_edge, ba_edge;
    logic      ab_clk_q, ba_clk_q;

    assign ab_ctrl = '{le: ab_le, dclk: ab_clk_in, ce_n: ab_ce_n};
    assign ba_ctrl = '{le: ba_le, dclk: ba_clk_in, ce_n: ba_ce_n};

    xcvr_lane #(.W(W)) u_ab (
        .clk       (clk),
        .rst       (rst),
        .din       (a_in),
        .ctrl      (ab_ctrl),
        .dout      (b_out),
        .edge_seen (ab_edge),
        .dclk_q    (ab_clk_q)
    );

    xcvr_lane #(.W(W)) u_ba (
        .clk       (clk),
        .rst       (rst),
        .din       (b_in),
        .ctrl      (ba_ctrl),
        .dout      (a_out),
        .edge_seen (ba_edge),
        .dclk_q    (ba_clk_q)
    );

    xcvr_oe_sync u_boe (
        .clk       (clk),
        .rst       (rst),
        .edge_seen (ab_edge),
        .oe_n      (ab_oe_n),
        .drv_en    (b_oe)
    );

    assign a_oe    = ~ba_oe_n & ~rst;
    assign fwd_clk = ab_clk_q;

    AST_FWD_FOLLOWS_CLK: assert property (@(posedge clk) disable iff (rst)
        $rose(fwd_clk) |-> $past(ab_clk_in)) // R8
        else $error("forwarded clock rose without a source edge");

    AST_DATA_WITH_FWD: assert property (@(posedge clk) disable iff (rst)
        ($rose(fwd_clk) && !ab_le && $past(!ab_le && !ab_ce_n)) |-> (b_out == $past(a_in))) // R8
        else $error("B data lags the forwarded clock");

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!b_oe && !fwd_clk)) // R9
        else $error("drivers active after reset");

endmodule

// File: tb/bus_xcvr_tb_top.sv
module bus_xcvr_tb_top;

    localparam int W = 17;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe, fwd_clk;
    logic         ab_le, ab_clk_in, ab_ce_n, ab_oe_n;
    logic         ba_le, ba_clk_in, ba_ce_n, ba_oe_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bus_xcvr #(.W(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_le(ab_le), .ab_clk_in(ab_clk_in), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_clk_in(ba_clk_in), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
        .fwd_clk(fwd_clk)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        a_in = '0; b_in = '0;
        ab_le = 0; ab_clk_in = 0; ab_ce_n = 1; ab_oe_n = 1;
        ba_le = 0; ba_clk_in = 0; ba_ce_n = 1; ba_oe_n = 0;
        repeat (3) after_edge();
        chk("R9 b_oe", W'(b_oe), W'(0));
        chk("R9 a_oe", W'(a_oe), W'(0));
        chk("R9 fwd_clk", W'(fwd_clk), W'(0));
        @(negedge clk);
        rst = 1'b0; ba_oe_n = 1;
        after_edge();
        chk("R9 b_out", b_out, '0);
        chk("R9 a_out", a_out, '0);
    endtask

    task automatic t_transparent();
        @(negedge clk);
        ab_le = 1; a_in = 17'h1A5A5;
        ba_le = 1; b_in = 17'h05A5A;
        #1;
        chk("R2 b_out pass", b_out, 17'h1A5A5);
        chk("R2 a_out pass", a_out, 17'h05A5A);
        a_in = 17'h0F0F0;
        b_in = 17'h10F0F;
        #1;
        chk("R2 b_out follow", b_out, 17'h0F0F0);
        chk("R1 a_out top bit", a_out, 17'h10F0F);
    endtask

    task automatic t_latch();
        @(negedge clk);
        ab_le = 1; a_in = 17'h13579;
        ba_le = 1; b_in = 17'h02468;
        @(negedge clk);
        ab_le = 0; a_in = 17'h0AAAA;
        ba_le = 0; b_in = 17'h15555;
        #1;
        chk("R3 b_out held", b_out, 17'h13579);
        chk("R3 a_out held", a_out, 17'h02468);
        after_edge();
        after_edge();
        chk("R3 b_out still held", b_out, 17'h13579);
        chk("R3 a_out still held", a_out, 17'h02468);
    endtask

    task automatic t_capture();
        @(negedge clk);
        ab_clk_in = 0; ab_ce_n = 0; a_in = 17'h1C3C3;
        ba_clk_in = 0; ba_ce_n = 0; b_in = 17'h03C3C;
        after_edge();
        chk("R8 fwd low before edge", W'(fwd_clk), W'(0));
        @(negedge clk);
        ab_clk_in = 1; ba_clk_in = 1;
        #1;
        chk("R4 b_out before edge", b_out, 17'h13579);
        after_edge();
        chk("R4 b_out captured", b_out, 17'h1C3C3);
        chk("R8 fwd rises with data", W'(fwd_clk), W'(1));
        chk("R4 a_out captured", a_out, 17'h03C3C);
        @(negedge clk);
        a_in = 17'h00001; b_in = 17'h1FFFF;
        after_edge();
        chk("R4 no load while clock high", b_out, 17'h1C3C3);
        @(negedge clk);
        ab_clk_in = 0; ba_clk_in = 0;
        after_edge();
    endtask

    task automatic t_gated();
        @(negedge clk);
        ab_ce_n = 1; ba_ce_n = 1; ab_clk_in = 1; ba_clk_in = 1;
        a_in = 17'h0BEEF; b_in = 17'h1CAFE;
        after_edge();
        chk("R5 b_out unchanged", b_out, 17'h1C3C3);
        chk("R5 a_out unchanged", a_out, 17'h03C3C);
        @(negedge clk);
        ab_clk_in = 0; ba_clk_in = 0;
        after_edge();
    endtask

    task automatic t_priority();
        @(negedge clk);
        ab_le = 1; ab_ce_n = 0; ab_clk_in = 1; a_in = 17'h11111;
        ba_le = 1; ba_ce_n = 0; ba_clk_in = 1; b_in = 17'h02222;
        after_edge();
        a_in = 17'h03333; b_in = 17'h14444;
        #1;
        chk("R6 b_out transparent wins", b_out, 17'h03333);
        chk("R6 a_out transparent wins", a_out, 17'h14444);
        @(negedge clk);
        ab_le = 0; ba_le = 0; ab_clk_in = 0; ba_clk_in = 0;
        ab_ce_n = 1; ba_ce_n = 1;
        after_edge();
    endtask

    task automatic t_oe();
        @(negedge clk);
        ab_oe_n = 0;
        after_edge();
        chk("R7 b_oe waits for edge", W'(b_oe), W'(0));
        @(negedge clk);
        ab_clk_in = 1; ab_ce_n = 0; a_in = 17'h16A6A;
        after_edge();
        chk("R7 b_oe on edge", W'(b_oe), W'(1));
        chk("R8 data with fwd", b_out, 17'h16A6A);
        chk("R8 fwd high", W'(fwd_clk), W'(1));
        @(negedge clk);
        ab_clk_in = 0; ab_oe_n = 1; ab_ce_n = 1;
        after_edge();
        chk("R7 b_oe holds without edge", W'(b_oe), W'(1));
        @(negedge clk);
        ab_clk_in = 1;
        after_edge();
        chk("R7 b_oe off on gated edge", W'(b_oe), W'(0));
        @(negedge clk);
        ab_clk_in = 0; ba_oe_n = 0;
        #1;
        chk("R7 a_oe immediate", W'(a_oe), W'(1));
        ba_oe_n = 1;
        #1;
        chk("R7 a_oe off", W'(a_oe), W'(0));
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_latch();
        t_capture();
        t_gated();
        t_priority();
        t_oe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule